// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block computes even parity for the address and data phases that the interface drives onto a 64-bit PCI bus. It also checks the parity bits that arrive with phases the interface receives. The bus is cut into 32-bit lanes. Lane 0 is AD[31:0] with CBE[3:0], and its parity pin is PAR. Lane 1 is AD[63:32] with CBE[7:4], and its parity pin is PAR64. For each lane the block produces a parity bit that makes the count of ones over the lane and its parity bit even.

The parity pin follows the values it covers by one clock, for both generated and received parity. The block therefore registers each phase's lane parity and its qualifiers at the clock edge that ends the phase. In the next cycle it compares the stored value with the arriving parity pins. It registers the verdict at the edge after that.

A mismatch on a received data phase drives the active-low data-error line. A mismatch on a received address phase drives the active-low system-error line. Each of these obeys its enable bits in the Command register. Two one-cycle pulses tell the Status register when to set its detected-parity-error bit (bit 15) and its signalled-system-error bit (bit 14).

Top module: `pci_parity_engine`

## Requirements
- R1: `par_tx[0]` in the clock after a phase equals the XOR of that phase's AD[31:0] and CBE[3:0], so ones over those bits plus the parity bit are even.
- R2: `par_tx[1]` in the clock after a phase equals the XOR of that phase's AD[63:32] and CBE[7:4].
- R3: A received data phase whose lane-0 parity, sampled on `par_rx[0]` one clock later, mismatches drives `perr_n` low for exactly one cycle, two clocks after the phase, when `cmd_reg[6]` is 1.
- R4: With `cmd_reg[6]` at 0 during the compare cycle, a data-phase parity error leaves `perr_n` high.
- R5: A received address phase with a parity mismatch drives `serr_n` low for one cycle, two clocks after the phase, only when `cmd_reg[6]` and `cmd_reg[8]` are both 1.
- R6: The lane-1 parity (`par_rx[1]`) is checked only for phases flagged with `wide_phase`. A mismatch there counts as an error like a lane-0 mismatch. Without the flag, the upper lane is ignored.
- R7: `stat_det_set` pulses for one cycle, two clocks after any received address or data phase with a parity error, whatever the Command bits.
- R8: `stat_sig_set` pulses in the same cycle that `serr_n` is driven low, and at no other time.
- R9: Phases driven by this interface (`drive_phase` = 1) and cycles with neither phase flag are never checked.
- R10: During and right after reset, `perr_n` and `serr_n` are 1, both status pulses are 0 and `par_tx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 64 | Address/data value of the current phase |
| cbe_in | input | 8 | Command/byte enables of the current phase |
| par_rx | input | 2 | Received parity, bit 0 for lane 0 and bit 1 for lane 1, one clock after the phase |
| addr_phase | input | 1 | Current cycle is an address phase |
| data_phase | input | 1 | Current cycle is a data phase |
| drive_phase | input | 1 | This interface drives the current phase |
| wide_phase | input | 1 | Current phase uses the 64-bit extension |
| cmd_reg | input | 16 | Command register; bit 6 enables parity response, bit 8 enables system error |
| par_tx | output | 2 | Generated parity, bit 0 for the PAR pin and bit 1 for the PAR64 pin |
| perr_n | output | 1 | Data parity error request, active low |
| serr_n | output | 1 | Address parity error request, active low |
| stat_det_set | output | 1 | Pulse to set the detected-parity-error status bit |
| stat_sig_set | output | 1 | Pulse to set the signalled-system-error status bit |

## Verification
Generated parity is due one clock after the phase, so the bench reads `par_tx` at the falling edge that follows the capturing rising edge. The received parity bits are applied in that same cycle. The error lines and status pulses are due two clocks after the phase, and the bench samples them one falling edge later. It then samples once more to confirm that each pulse lasts exactly one cycle. Every vector leaves the qualifiers idle after its phase, so no result from one vector can fall into the window of another.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    localparam int LANE_AD_W = 32;
    localparam int LANE_BE_W = 4;

    typedef struct packed {
        logic chk_addr;
        logic chk_data;
        logic chk_wide;
    } phase_q_t;

    typedef struct packed {
        logic perr;
        logic serr;
        logic det;
        logic sig;
    } err_flags_t;

endpackage

// File: rtl/par_lane_xor.sv
module par_lane_xor #(
    parameter int W = 36
) (
    input  logic [W-1:0] bits,
    output logic         par
);
    // Parity bit that makes the lane plus this bit carry an even count of ones.
    assign par = ^bits;
endmodule

// File: rtl/par_err_judge.sv
module par_err_judge #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] lane_gen,
    input  logic [LANES-1:0] lane_rx,
    input  logic             chk_addr,
    input  logic             chk_data,
    input  logic             chk_wide,
    input  logic             resp_en,
    input  logic             sys_en,
    output logic             addr_err,
    output logic             data_err,
    output logic             perr_req,
    output logic             serr_req
);
    logic [LANES-1:0] lane_mask;
    logic [LANES-1:0] lane_bad;
    logic             any_bad;

    // Lane 0 is always covered; the upper lanes only on 64-bit phases.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        if (g == 0) begin : g_base
            assign lane_mask[g] = 1'b1;
        end else begin : g_ext
            assign lane_mask[g] = chk_wide;
        end
    end

    always_comb begin
        lane_bad = (lane_gen ^ lane_rx) & lane_mask;
        any_bad  = |lane_bad;
        data_err = chk_data & any_bad;
        addr_err = chk_addr & any_bad;
        perr_req = data_err & resp_en;
        serr_req = addr_err & resp_en & sys_en;
    end
endmodule

// File: rtl/pci_parity_engine.sv
module pci_parity_engine
    import pci_par_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int CMD_W       = 16,
    parameter int PERR_EN_BIT = 6,
    parameter int SERR_EN_BIT = 8,
    localparam int AD_W       = LANES * LANE_AD_W,
    localparam int BE_W       = LANES * LANE_BE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_in,
    input  logic [BE_W-1:0]  cbe_in,
    input  logic [LANES-1:0] par_rx,
    input  logic             addr_phase,
    input  logic             data_phase,
    input  logic             drive_phase,
    input  logic             wide_phase,
    input  logic [CMD_W-1:0] cmd_reg,
    output logic [LANES-1:0] par_tx,
    output logic             perr_n,
    output logic             serr_n,
    output logic             stat_det_set,
    output logic             stat_sig_set
);

    typedef struct packed {
        logic [LANES-1:0] lane_par;
        phase_q_t         phase;
        err_flags_t       flags;
        logic [1:0]       started;
    } state_t;

    localparam state_t STATE_RST = '0;

    state_t           st_d, st_q;
    logic [LANES-1:0] lane_now;
    logic             addr_err, data_err, perr_req, serr_req;

    // One XOR tree per 32-bit lane with its four byte enables.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        par_lane_xor #(.W(LANE_AD_W + LANE_BE_W)) u_lane (
            .bits ({ad_in[g*LANE_AD_W +: LANE_AD_W], cbe_in[g*LANE_BE_W +: LANE_BE_W]}),
            .par  (lane_now[g])
        );
    end

    // Compare cycle: the stored phase meets the parity pins that trail it.
    par_err_judge #(.LANES(LANES)) u_judge (
        .lane_gen (st_q.lane_par),
        .lane_rx  (par_rx),
        .chk_addr (st_q.phase.chk_addr),
        .chk_data (st_q.phase.chk_data),
        .chk_wide (st_q.phase.chk_wide),
        .resp_en  (cmd_reg[PERR_EN_BIT]),
        .sys_en   (cmd_reg[SERR_EN_BIT]),
        .addr_err (addr_err),
        .data_err (data_err),
        .perr_req (perr_req),
        .serr_req (serr_req)
    );

    always_comb begin
        st_d                = st_q;
        st_d.lane_par       = lane_now;
        st_d.phase.chk_addr = addr_phase & ~drive_phase;
        st_d.phase.chk_data = data_phase & ~drive_phase;
        st_d.phase.chk_wide = wide_phase;
        st_d.flags.perr     = perr_req;
        st_d.flags.serr     = serr_req;
        st_d.flags.det      = addr_err | data_err;
        st_d.flags.sig      = serr_req;
        st_d.started        = {st_q.started[0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_tx       = st_q.lane_par;
    assign perr_n       = ~st_q.flags.perr;
    assign serr_n       = ~st_q.flags.serr;
    assign stat_det_set = st_q.flags.det;
    assign stat_sig_set = st_q.flags.sig;

    // R1
    par_lo_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started[0] |-> par_tx[0] == $past(^{ad_in[LANE_AD_W-1:0], cbe_in[LANE_BE_W-1:0]}));

    // R3
    perr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(cmd_reg[PERR_EN_BIT]));

    // R5
    serr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(cmd_reg[PERR_EN_BIT] && cmd_reg[SERR_EN_BIT]));

    // R7
    perr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_n || !serr_n) |-> stat_det_set);

    // R9
    perr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started[1] && !perr_n) |-> $past(data_phase && !drive_phase, 2));

    // R9
    serr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started[1] && !serr_n) |-> $past(addr_phase && !drive_phase, 2));

endmodule

// File: tb/pci_parity_engine_tb.sv
module pci_parity_engine_tb;

    typedef struct packed {
        logic [63:0] ad;
        logic [7:0]  cbe;
        logic        is_addr;
        logic        is_data;
        logic        drv;
        logic        wide;
        logic        flo;
        logic        fhi;
        logic        c6;
        logic        c8;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R3 clean data phase, no error
        '{64'h0123_4567_89AB_CDEF, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        // R3 lane-0 error, response enabled
        '{64'hDEAD_BEEF_0000_0001, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        // R4 lane-0 error, response disabled
        '{64'h0000_0000_FFFF_0000, 8'h0F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        // R6 lane-1 error on a 64-bit phase
        '{64'h8000_0000_0000_0003, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        // R6 lane-1 error ignored on a 32-bit phase
        '{64'h1111_2222_3333_4444, 8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        // R5 address error, both enables
        '{64'h0000_0000_1000_0000, 8'h06, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        // R5 address error, system error disabled
        '{64'h0000_0000_2000_0004, 8'h07, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        // R6 address error on the upper lane
        '{64'hCAFE_F00D_0000_0100, 8'h6C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        // R9 driven data phase is not checked
        '{64'h5555_AAAA_5555_AAAA, 8'h99, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        // R9 idle cycle is not checked
        '{64'h7777_0000_0000_7777, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        // R1 R2 all ones, clean
        '{64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ad_in = '0;
    logic [7:0]  cbe_in = '0;
    logic [1:0]  par_rx = '0;
    logic        addr_phase = 1'b0;
    logic        data_phase = 1'b0;
    logic        drive_phase = 1'b0;
    logic        wide_phase = 1'b0;
    logic [15:0] cmd_reg = '0;
    logic [1:0]  par_tx;
    logic        perr_n, serr_n, stat_det_set, stat_sig_set;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pci_parity_engine u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ad_in        (ad_in),
        .cbe_in       (cbe_in),
        .par_rx       (par_rx),
        .addr_phase   (addr_phase),
        .data_phase   (data_phase),
        .drive_phase  (drive_phase),
        .wide_phase   (wide_phase),
        .cmd_reg      (cmd_reg),
        .par_tx       (par_tx),
        .perr_n       (perr_n),
        .serr_n       (serr_n),
        .stat_det_set (stat_det_set),
        .stat_sig_set (stat_sig_set)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        check("R10 perr_n", 32'(perr_n), 32'd1);
        check("R10 serr_n", 32'(serr_n), 32'd1);
        check("R10 det", 32'(stat_det_set), 32'd0);
        check("R10 sig", 32'(stat_sig_set), 32'd0);
        check("R10 par_tx", 32'(par_tx), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 perr_n after release", 32'(perr_n), 32'd1);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic exp_lo, exp_hi, recv, bad, de, ae;
            v = VECS[i];
            ad_in       = v.ad;
            cbe_in      = v.cbe;
            addr_phase  = v.is_addr;
            data_phase  = v.is_data;
            drive_phase = v.drv;
            wide_phase  = v.wide;
            cmd_reg     = '0;
            cmd_reg[6]  = v.c6;
            cmd_reg[8]  = v.c8;
            par_rx      = '0;
            @(negedge clk);
            exp_lo = ^{v.ad[31:0], v.cbe[3:0]};
            exp_hi = ^{v.ad[63:32], v.cbe[7:4]};
            check("R1 par_tx[0]", 32'(par_tx[0]), 32'(exp_lo));
            check("R2 par_tx[1]", 32'(par_tx[1]), 32'(exp_hi));
            par_rx      = {exp_hi ^ v.fhi, exp_lo ^ v.flo};
            ad_in       = ~v.ad;
            cbe_in      = ~v.cbe;
            addr_phase  = 1'b0;
            data_phase  = 1'b0;
            drive_phase = 1'b0;
            wide_phase  = 1'b0;
            @(negedge clk);
            recv = !v.drv;
            bad  = v.flo | (v.wide & v.fhi);
            de   = v.is_data & recv & bad;
            ae   = v.is_addr & recv & bad;
            check("R3,R4,R6,R9 perr_n", 32'(perr_n), 32'(!(de & v.c6)));
            check("R5,R6,R9 serr_n", 32'(serr_n), 32'(!(ae & v.c6 & v.c8)));
            check("R7 stat_det_set", 32'(stat_det_set), 32'(de | ae));
            check("R8 stat_sig_set", 32'(stat_sig_set), 32'(ae & v.c6 & v.c8));
            par_rx = '0;
            @(negedge clk);
            check("R3 perr_n one cycle", 32'(perr_n), 32'd1);
            check("R5 serr_n one cycle", 32'(serr_n), 32'd1);
            check("R7 det one cycle", 32'(stat_det_set), 32'd0);
        end

        // R3 back-to-back errored data phases give two pulses
        cmd_reg     = 16'h0040;
        ad_in       = 64'h0;
        cbe_in      = 8'h0;
        data_phase  = 1'b1;
        @(negedge clk);
        par_rx = 2'b01;
        ad_in  = 64'h1;
        @(negedge clk);
        data_phase = 1'b0;
        par_rx     = 2'b00;
        check("R3 first pulse", 32'(perr_n), 32'd0);
        @(negedge clk);
        check("R3 second pulse", 32'(perr_n), 32'd0);
        @(negedge clk);
        check("R3 pulses end", 32'(perr_n), 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule